// File: doc/BRIEF.md
# LVDS Transmitter PHY Control Register Block

This block holds the control word for a two-channel LVDS transmitter PHY and presents it as a small set of memory-mapped registers on a single-cycle, word-addressed register bus. The control word packs a PLL divider select, two bias-trim fields, a six-bit test field, one enable per channel, a 10-bit serialization mode flag, a feedback select and a power-down flag. Each field is driven straight to the analog PHY as its own output.

Software can update the control word in three ways. It can write the whole word at the base offset. It can OR bits in through a set alias. It can clear bits through a clear alias, so that a channel enable can change without a read-modify-write. A separate strobe loads the initialization value into the tuning and mode fields and leaves the channel enables and power-down alone. A read-only status word shows the PLL lock input after it has passed through a synchronizer. Reads return data combinationally in the same cycle as the address.

Top module: `lvds_phy_csr`

## Requirements
- R1: After reset the control word is 0x124A0: divider 0, bias A 4, bias B 4, test field 0x25, and all other bits 0.
- R2: A write to offset 0x00 replaces control bits 18:0 with the write data on the clock edge that samples the strobe. Without a control write or a load strobe, the control word holds.
- R3: A write to offset 0x04 ORs the write data into the control word on the next clock edge.
- R4: A write to offset 0x08 clears every control bit that is 1 in the write data on the next clock edge.
- R5: A load_defaults pulse sets divider 0, bias B 5, bias A 4, test field 0x25, ten_bit 0 and fb_sel 1 (mask 0x7FFE6, value 0x164A2). It keeps the channel enables and power-down. On the fields it covers, it wins over a bus write in the same cycle.
- R6: Offset 0x10 reads the PLL lock input in bit 0, two clock edges after that input changes, with bits 31:1 zero. Writes to 0x10, or to any unmapped offset, leave the control word unchanged.
- R7: Reads of 0x00, 0x04 and 0x08 return the control word, with bits 31:19 zero. Reads of unmapped offsets return zero.
- R8: The outputs follow the control word layout: div_sel = bits 18:17, bias_b = 16:14, bias_a = 13:11, test_cfg = 10:5, ch_en[n] = bit 3+n, ten_bit = bit 2, fb_sel = bit 1, pwr_down = bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| load_defaults | input | 1 | Loads the initialization value into the tuning and mode fields |
| pll_lock_in | input | 1 | Asynchronous PLL lock indication |
| div_sel | output | 2 | PLL divider select |
| bias_b | output | 3 | Bias trim field B |
| bias_a | output | 3 | Bias trim field A |
| test_cfg | output | 6 | Analog test field |
| ch_en | output | 2 | Per-channel enable |
| ten_bit | output | 1 | 10-bit serialization mode |
| fb_sel | output | 1 | Feedback select |
| pwr_down | output | 1 | PHY power down |

## Verification
The control word is the only state that matters. If it is wrong, a field output is wrong on the cycle right after the faulty update, and every alias read shows the same wrong value. Each check therefore compares the field outputs and a read-back one cycle after a write, against a bench model of the set, clear and load rules. A fault in the lock path shows up as a status bit that changes one edge too early or too late, so the lock check samples after the first edge and again after the second.

// File: rtl/lvds_csr_pkg.sv
package lvds_csr_pkg;
  localparam int DATA_W  = 32;
  localparam int CTRL_W  = 19;
  localparam int NUM_CH  = 2;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_SET  = 'h04;
  localparam int OFS_CLR  = 'h08;
  localparam int OFS_STAT = 'h10;

  localparam int DIV_LSB  = 17;
  localparam int DIV_W    = 2;
  localparam int BIASB_LSB = 14;
  localparam int BIASB_W  = 3;
  localparam int BIASA_LSB = 11;
  localparam int BIASA_W  = 3;
  localparam int TST_LSB  = 5;
  localparam int TST_W    = 6;
  localparam int CHEN_LSB = 3;
  localparam int TEN_BIT  = 2;
  localparam int FB_BIT   = 1;
  localparam int PD_BIT   = 0;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 19'h124A0;
  localparam logic [CTRL_W-1:0] LOAD_VAL   = 19'h164A2;
  localparam logic [CTRL_W-1:0] LOAD_MASK  = 19'h7FFE6;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_SET   = 2'd2,
    ACC_CLEAR = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    RD_CTRL = 2'd0,
    RD_STAT = 2'd1,
    RD_ZERO = 2'd2
  } rdsel_e;
endpackage

// File: rtl/lvds_csr_decode.sv
module lvds_csr_decode
  import lvds_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output acc_e              wr_kind,
  output rdsel_e            rd_sel
);
  always_comb begin
    wr_kind = ACC_NONE;
    rd_sel  = RD_ZERO;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rd_sel = RD_CTRL;
      if (we) wr_kind = ACC_WRITE;
    end else if (addr == ADDR_W'(OFS_SET)) begin
      rd_sel = RD_CTRL;
      if (we) wr_kind = ACC_SET;
    end else if (addr == ADDR_W'(OFS_CLR)) begin
      rd_sel = RD_CTRL;
      if (we) wr_kind = ACC_CLEAR;
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      rd_sel = RD_STAT;
    end
  end
endmodule

// File: rtl/lvds_csr_ctrl_reg.sv
module lvds_csr_ctrl_reg
  import lvds_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              wr_kind,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load_defaults,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] wfield;
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;

  assign wfield = wdata[CTRL_W-1:0];

  always_comb begin
    ctrl_d = ctrl_q;
    unique case (wr_kind)
      ACC_WRITE: ctrl_d = wfield;
      ACC_SET:   ctrl_d = ctrl_q | wfield;
      ACC_CLEAR: ctrl_d = ctrl_q & ~wfield;
      default:   ctrl_d = ctrl_q;
    endcase
    if (load_defaults) ctrl_d = (ctrl_d & ~LOAD_MASK) | LOAD_VAL;
  end

  assign ctrl_en = (wr_kind != ACC_NONE) || load_defaults;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == ACC_WRITE && !load_defaults) |=> ctrl_q == $past(wfield));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == ACC_NONE && !load_defaults) |=> $stable(ctrl_q));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == ACC_SET && !load_defaults) |=>
      ((ctrl_q & $past(wfield)) == $past(wfield)) &&
      ((ctrl_q & ~$past(wfield)) == ($past(ctrl_q) & ~$past(wfield))));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == ACC_CLEAR && !load_defaults) |=>
      ((ctrl_q & $past(wfield)) == '0) &&
      ((ctrl_q & ~$past(wfield)) == ($past(ctrl_q) & ~$past(wfield))));
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_defaults |=> (ctrl_q & LOAD_MASK) == LOAD_VAL);
endmodule

// File: rtl/lvds_csr_sync.sv
module lvds_csr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic stage_d;
      if (i == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_next
        assign stage_d = chain_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lvds_phy_csr.sv
module lvds_phy_csr
  import lvds_csr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              load_defaults,
  input  logic              pll_lock_in,
  output logic [DIV_W-1:0]  div_sel,
  output logic [BIASB_W-1:0] bias_b,
  output logic [BIASA_W-1:0] bias_a,
  output logic [TST_W-1:0]  test_cfg,
  output logic [NUM_CH-1:0] ch_en,
  output logic              ten_bit,
  output logic              fb_sel,
  output logic              pwr_down
);
  acc_e              wr_kind;
  rdsel_e            rd_sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic              lock_sync;

  lvds_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (bus_addr),
    .we      (bus_we),
    .wr_kind (wr_kind),
    .rd_sel  (rd_sel)
  );

  lvds_csr_ctrl_reg u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_kind       (wr_kind),
    .wdata         (bus_wdata),
    .load_defaults (load_defaults),
    .ctrl_q        (ctrl_q)
  );

  lvds_csr_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pll_lock_in),
    .sync_out (lock_sync)
  );

  always_comb begin
    unique case (rd_sel)
      RD_CTRL: bus_rdata = DATA_W'(ctrl_q);
      RD_STAT: bus_rdata = DATA_W'(lock_sync);
      default: bus_rdata = '0;
    endcase
  end

  assign div_sel  = ctrl_q[DIV_LSB +: DIV_W];
  assign bias_b   = ctrl_q[BIASB_LSB +: BIASB_W];
  assign bias_a   = ctrl_q[BIASA_LSB +: BIASA_W];
  assign test_cfg = ctrl_q[TST_LSB +: TST_W];
  assign ch_en    = ctrl_q[CHEN_LSB +: NUM_CH];
  assign ten_bit  = ctrl_q[TEN_BIT];
  assign fb_sel   = ctrl_q[FB_BIT];
  assign pwr_down = ctrl_q[PD_BIT];

  p_stat_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_STAT) && !load_defaults) |=> $stable(ctrl_q));
  p_rdata_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:CTRL_W] == '0);
endmodule

// File: tb/lvds_phy_csr_tb_top.sv
module lvds_phy_csr_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        load_defaults;
  logic        pll_lock_in;
  logic [1:0]  div_sel;
  logic [2:0]  bias_b;
  logic [2:0]  bias_a;
  logic [5:0]  test_cfg;
  logic [1:0]  ch_en;
  logic        ten_bit;
  logic        fb_sel;
  logic        pwr_down;

  int n_checks = 0;
  int n_fail   = 0;
  logic [18:0] model;

  lvds_phy_csr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_defaults(load_defaults),
    .pll_lock_in(pll_lock_in), .div_sel(div_sel), .bias_b(bias_b), .bias_a(bias_a),
    .test_cfg(test_cfg), .ch_en(ch_en), .ten_bit(ten_bit), .fb_sel(fb_sel),
    .pwr_down(pwr_down)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [18:0] next_ctrl(logic [18:0] cur, logic we, logic [7:0] a,
                                            logic [31:0] d, logic ld);
    logic [18:0] r;
    r = cur;
    if (we) begin
      if (a == 8'h00) r = d[18:0];
      else if (a == 8'h04) r = cur | d[18:0];
      else if (a == 8'h08) r = cur & ~d[18:0];
    end
    if (ld) begin
      r[18:17] = 2'd0; r[16:14] = 3'd5; r[13:11] = 3'd4; r[10:5] = 6'h25;
      r[2] = 1'b0; r[1] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_fields(string req);
    logic [18:0] f;
    f = {div_sel, bias_b, bias_a, test_cfg, ch_en, ten_bit, fb_sel, pwr_down};
    check(req, {13'd0, f}, {13'd0, model});
  endtask

  task automatic read_check(logic [7:0] a, logic [31:0] exp, string req);
    bus_we = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic ld, string req);
    bus_we = we; bus_addr = a; bus_wdata = d; load_defaults = ld;
    @(posedge clk);
    model = next_ctrl(model, we, a, d, ld);
    @(negedge clk);
    bus_we = 1'b0; load_defaults = 1'b0;
    check_fields(req);
  endtask

  initial begin
    #3000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    load_defaults = 1'b0; pll_lock_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model = 19'h124A0;
    check_fields("R1 reset fields");
    read_check(8'h00, 32'h0001_24A0, "R1 reset read");
    read_check(8'h10, 32'h0, "R6 status after reset");

    step(1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0, "R2 full write");
    read_check(8'h00, 32'h0007_FFFF, "R7 upper bits zero");
    read_check(8'h08, 32'h0007_FFFF, "R7 clear alias read");
    step(1'b1, 8'h08, 32'h0000_0018, 1'b0, "R4 clear both channels");
    check("R8 ch_en cleared", {30'd0, ch_en}, 32'd0);
    step(1'b1, 8'h04, 32'h0000_0010, 1'b0, "R3 set channel 1");
    check("R8 ch_en bit 4", {30'd0, ch_en}, 32'd2);
    step(1'b1, 8'h10, 32'h0000_0000, 1'b0, "R6 status write ignored");
    step(1'b1, 8'h20, 32'h0000_0000, 1'b0, "R6 unmapped write ignored");
    read_check(8'h20, 32'h0, "R7 unmapped read zero");
    read_check(8'h04, {13'd0, model}, "R7 set alias read");
    step(1'b0, 8'h00, 32'h0, 1'b1, "R5 load keeps ch_en and pwr_down");
    check("R5 ten_bit cleared", {31'd0, ten_bit}, 32'd0);
    step(1'b1, 8'h00, 32'h0000_0000, 1'b1, "R5 load wins over write");

    pll_lock_in = 1'b1;
    @(posedge clk); @(negedge clk);
    read_check(8'h10, 32'h0, "R6 lock not yet visible");
    @(posedge clk); @(negedge clk);
    read_check(8'h10, 32'h1, "R6 lock visible after two edges");
    pll_lock_in = 1'b0;
    @(posedge clk); @(negedge clk);
    read_check(8'h10, 32'h1, "R6 unlock not yet visible");
    @(posedge clk); @(negedge clk);
    read_check(8'h10, 32'h0, "R6 unlock visible");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic ld;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        3: a = 8'h10;
        4: a = 8'h0C;
        default: a = 8'(($urandom_range(0, 63)) << 2);
      endcase
      d  = $urandom;
      ld = ($urandom_range(0, 7) == 0);
      step($urandom_range(0, 3) != 0, a, d, ld, "R2 R3 R4 R5 random update");
      if (i % 8 == 0) begin
        pll_lock_in = $urandom_range(0, 1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        read_check(8'h10, {31'd0, pll_lock_in}, "R6 random lock");
      end
      read_check(8'h00, {13'd0, model}, "R7 control read");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule